// File: doc/BRIEF.md
# Host Controller Command and Status Registers

This block holds the command word and the status word of a USB host controller and exposes both on a simple single-cycle register bus. The command word starts and stops the schedule engine, launches a controller reset, selects the frame list length and turns the periodic and asynchronous schedules on or off. The status word carries a halted flag and a row of latched event bits that software clears by writing ones.

The schedule engine sits beside the block. It receives a run request and a reset request. It answers with a level saying its pipeline has drained and with a one-cycle pulse when its internal reset is finished. Stopping is a two-step handshake: clearing run/stop withdraws the run request, and the halted flag is set only once the engine reports it is idle. A controller reset clears itself when the engine pulses reset-done, and it puts both words back to their power-up values. A mask of usable frame-index bits, derived from the selected list length, is driven for the frame counter.

Top module: `hc_cmdsts_regs`

## Requirements
- R1: After reset the command word (offset 0x20) reads 0, the status word (offset 0x24) reads 0x0000_1000 (halted flag at bit 12 set, event bits 5:0 clear), and the frame-index mask is 0x3FF.
- R2: Command bit 0 is run/stop and drives `run_req` from the clock edge of the write. The halted flag stays 1 in the cycle after that edge and reads 0 one cycle later.
- R3: Once run/stop is 0, the halted flag becomes 1 in the cycle after `eng_idle` is seen high. While `eng_idle` is low it stays 0.
- R4: Command bit 1 is controller reset. A write of 1 sets it and drives `hc_reset_req`. A later write of 0 does not clear it. It clears in the cycle after a `rst_done` pulse.
- R5: When a reset completes, the command word returns to 0 and the status word returns to 0x0000_1000, whatever was written or latched before.
- R6: With the programmable-length parameter at 1, command bits 3:2 select the frame list length: 00 gives a mask of 0x3FF, 01 gives 0x1FF and 10 gives 0x0FF. A write of 11 leaves the field and the mask unchanged, while the other bits of that write still take effect.
- R7: With the programmable-length parameter at 0, bits 3:2 read 00 whatever is written, and the mask stays 0x3FF.
- R8: Command bit 4 enables the periodic schedule and drives `per_en`. Command bit 5 enables the asynchronous schedule and drives `async_en`. Both read back as written.
- R9: Command bits 31:6 read 0 whatever is written.
- R10: A high `evt_in[i]` sets status bit i (i = 0..5). A write to the status word with a 1 at bit i clears that bit, and a 0 leaves it unchanged. A set and a clear of the same bit in the same cycle leave it set. A write to bit 12 has no effect.
- R11: `seq_err` is high for exactly one cycle, in the cycle after a command write that sets bit 1 while the halted flag is 0. The same write made while halted does not raise it.
- R12: Reads from offsets other than 0x20 and 0x24 return 0. Writes to such offsets change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| evt_in | input | 6 | Event pulses that set status bits 5:0 |
| eng_idle | input | 1 | Engine pipeline has drained |
| rst_done | input | 1 | Engine reset finished (one-cycle pulse) |
| run_req | output | 1 | Run request to the engine |
| hc_reset_req | output | 1 | Controller reset in progress |
| per_en | output | 1 | Periodic schedule enable |
| async_en | output | 1 | Asynchronous schedule enable |
| fidx_mask | output | 10 | Usable frame-index bits |
| seq_err | output | 1 | Debug pulse: reset requested while running |

## Verification
The bench builds two copies of the block from the same stimulus. One has the programmable frame-list length enabled, which reaches every size code, the ignored reserved code and the mask outputs. The other has it disabled, which shows the length field staying at 00 under the same writes. Both use the default offsets, a 6-bit event field and a 10-bit frame index. With these values the reserved-bit masking, the halt and reset handshakes and the set-versus-clear race on event bits are all exercised.

// File: rtl/hc_regs_pkg.sv
package hc_regs_pkg;

    // Command word bit positions
    localparam int CMD_RUN    = 0;
    localparam int CMD_HCRST  = 1;
    localparam int CMD_FLS_LO = 2;
    localparam int CMD_FLS_HI = 3;
    localparam int CMD_PSE    = 4;
    localparam int CMD_ASE    = 5;
    localparam int CMD_USED   = 6;

    // Frame list length codes
    typedef enum logic [1:0] {
        FLS_1024 = 2'b00,
        FLS_512  = 2'b01,
        FLS_256  = 2'b10,
        FLS_RSVD = 2'b11
    } fls_e;

endpackage

// File: rtl/hc_fidx_mask.sv
module hc_fidx_mask
    import hc_regs_pkg::*;
#(
    parameter int FIDX_W = 10
) (
    input  fls_e              fls_i,
    output logic [FIDX_W-1:0] mask_o
);
    localparam logic [FIDX_W-1:0] FULL = {FIDX_W{1'b1}};

    // Each step of the size code drops one index bit from the top
    always_comb begin
        mask_o = FULL >> fls_i;
    end

endmodule

// File: rtl/hc_cmd_unit.sv
module hc_cmd_unit
    import hc_regs_pkg::*;
#(
    parameter bit PROG_FLS = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  logic [CMD_USED-1:0] wdata_i,
    input  logic                halted_i,
    input  logic                rst_done_i,
    output logic                run_o,
    output logic                hcrst_o,
    output fls_e                fls_o,
    output logic                pse_o,
    output logic                ase_o,
    output logic                seq_err_o,
    output logic                clr_all_o,
    output logic [31:0]         cmd_word_o
);
    typedef struct packed {
        logic run;
        logic hcrst;
        fls_e fls;
        logic pse;
        logic ase;
        logic seq_err;
    } cmd_t;

    localparam cmd_t CMD_RST = '{run: 1'b0, hcrst: 1'b0, fls: FLS_1024,
                                 pse: 1'b0, ase: 1'b0, seq_err: 1'b0};

    cmd_t cmd_d, cmd_q;
    logic fls_wr_ok;
    logic rst_finish;

    // Parameter picks whether the length field is writable at all
    generate
        if (PROG_FLS) begin : g_prog_fls
            always_comb fls_wr_ok = (wdata_i[CMD_FLS_HI:CMD_FLS_LO] != FLS_RSVD);
        end else begin : g_fixed_fls
            always_comb fls_wr_ok = 1'b0;
        end
    endgenerate

    always_comb rst_finish = cmd_q.hcrst && rst_done_i;

    always_comb begin
        cmd_d         = cmd_q;
        cmd_d.seq_err = 1'b0;
        if (wr_i) begin
            cmd_d.run = wdata_i[CMD_RUN];
            cmd_d.pse = wdata_i[CMD_PSE];
            cmd_d.ase = wdata_i[CMD_ASE];
            if (fls_wr_ok)
                cmd_d.fls = fls_e'(wdata_i[CMD_FLS_HI:CMD_FLS_LO]);
            if (wdata_i[CMD_HCRST]) begin
                cmd_d.hcrst   = 1'b1;
                cmd_d.seq_err = !halted_i;
            end
        end
        // Reset completion wins over any write in the same cycle
        if (rst_finish)
            cmd_d = CMD_RST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_q <= CMD_RST;
        else        cmd_q <= cmd_d;
    end

    always_comb begin
        run_o      = cmd_q.run;
        hcrst_o    = cmd_q.hcrst;
        fls_o      = cmd_q.fls;
        pse_o      = cmd_q.pse;
        ase_o      = cmd_q.ase;
        seq_err_o  = cmd_q.seq_err;
        clr_all_o  = rst_finish;
        cmd_word_o = '0;
        cmd_word_o[CMD_RUN]               = cmd_q.run;
        cmd_word_o[CMD_HCRST]             = cmd_q.hcrst;
        cmd_word_o[CMD_FLS_HI:CMD_FLS_LO] = cmd_q.fls;
        cmd_word_o[CMD_PSE]               = cmd_q.pse;
        cmd_word_o[CMD_ASE]               = cmd_q.ase;
    end

    // R4: reset request holds until the engine reports completion
    a_r4_reset_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q.hcrst && !rst_done_i) |=> cmd_q.hcrst);

    // R4: completion pulse ends the reset
    a_r4_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q.hcrst && rst_done_i) |=> !cmd_q.hcrst);

    // R5: completion leaves run and schedules off
    a_r5_cmd_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        rst_finish |=> (!cmd_q.run && !cmd_q.pse && !cmd_q.ase && cmd_q.fls == FLS_1024));

    // R6: reserved length code never reaches the register
    a_r6_no_rsvd_fls: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_q.fls != FLS_RSVD);

    // R11: illegal reset sequence is flagged
    a_r11_seq_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wdata_i[CMD_HCRST] && !halted_i && !rst_finish) |=> cmd_q.seq_err);

endmodule

// File: rtl/hc_sts_unit.sv
module hc_sts_unit #(
    parameter int EVT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt_i,
    input  logic             wr_i,
    input  logic [EVT_W-1:0] wdata_i,
    input  logic             run_i,
    input  logic             idle_i,
    input  logic             clr_all_i,
    output logic             halted_o,
    output logic [EVT_W-1:0] evts_o
);
    typedef struct packed {
        logic [EVT_W-1:0] evts;
        logic             halted;
    } sts_t;

    localparam sts_t STS_RST = '{evts: '0, halted: 1'b1};

    sts_t sts_d, sts_q;
    logic [EVT_W-1:0] clr_mask;

    always_comb begin
        clr_mask = wr_i ? wdata_i : '0;
        sts_d    = sts_q;
        // A new event beats a clear of the same bit
        sts_d.evts = (sts_q.evts & ~clr_mask) | evt_i;
        if (run_i)       sts_d.halted = 1'b0;
        else if (idle_i) sts_d.halted = 1'b1;
        if (clr_all_i)   sts_d = STS_RST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sts_q <= STS_RST;
        else        sts_q <= sts_d;
    end

    always_comb begin
        halted_o = sts_q.halted;
        evts_o   = sts_q.evts;
    end

    // R2: running drops the halted flag on the next edge
    a_r2_halt_falls: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !clr_all_i) |=> !sts_q.halted);

    // R3: halted rises only after a drained stop or a completed reset
    a_r3_halt_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_q.halted) |-> ($past(!run_i && idle_i) || $past(clr_all_i)));

    // R10: every raised event is latched
    a_r10_evt_latched: assert property (@(posedge clk) disable iff (!rst_n)
        ((|evt_i) && !clr_all_i) |=> ((sts_q.evts & $past(evt_i)) == $past(evt_i)));

    // R5: completion clears every event
    a_r5_sts_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all_i |=> (sts_q.evts == '0 && sts_q.halted));

endmodule

// File: rtl/hc_cmdsts_regs.sv
module hc_cmdsts_regs
    import hc_regs_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int          CMD_OFS  = 'h20,
    parameter int          STS_OFS  = 'h24,
    parameter int          EVT_W    = 6,
    parameter int          HALT_BIT = 12,
    parameter int          FIDX_W   = 10,
    parameter bit          PROG_FLS = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [EVT_W-1:0]  evt_in,
    input  logic              eng_idle,
    input  logic              rst_done,
    output logic              run_req,
    output logic              hc_reset_req,
    output logic              per_en,
    output logic              async_en,
    output logic [FIDX_W-1:0] fidx_mask,
    output logic              seq_err
);
    localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(CMD_OFS);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(STS_OFS);

    logic        sel_cmd, sel_sts;
    logic        halted, clr_all;
    fls_e        fls;
    logic [31:0] cmd_word, sts_word;
    logic [EVT_W-1:0] evts;

    always_comb begin
        sel_cmd = (bus_addr == A_CMD);
        sel_sts = (bus_addr == A_STS);
    end

    hc_cmd_unit #(.PROG_FLS(PROG_FLS)) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (bus_wr && sel_cmd),
        .wdata_i    (bus_wdata[CMD_USED-1:0]),
        .halted_i   (halted),
        .rst_done_i (rst_done),
        .run_o      (run_req),
        .hcrst_o    (hc_reset_req),
        .fls_o      (fls),
        .pse_o      (per_en),
        .ase_o      (async_en),
        .seq_err_o  (seq_err),
        .clr_all_o  (clr_all),
        .cmd_word_o (cmd_word)
    );

    hc_sts_unit #(.EVT_W(EVT_W)) u_sts (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_in),
        .wr_i      (bus_wr && sel_sts),
        .wdata_i   (bus_wdata[EVT_W-1:0]),
        .run_i     (run_req),
        .idle_i    (eng_idle),
        .clr_all_i (clr_all),
        .halted_o  (halted),
        .evts_o    (evts)
    );

    hc_fidx_mask #(.FIDX_W(FIDX_W)) u_mask (
        .fls_i  (fls),
        .mask_o (fidx_mask)
    );

    always_comb begin
        sts_word              = '0;
        sts_word[EVT_W-1:0]   = evts;
        sts_word[HALT_BIT]    = halted;
        if (sel_cmd)      bus_rdata = cmd_word;
        else if (sel_sts) bus_rdata = sts_word;
        else              bus_rdata = '0;
    end

    // R6: the mask is always a run of ones from bit 0 of at least 256 entries
    a_r6_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
        ((fidx_mask & (fidx_mask + 1'b1)) == '0) && (&fidx_mask[FIDX_W-3:0]));

    // R11: the debug flag never lasts two cycles
    a_r11_seq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_err && !(bus_wr && sel_cmd)) |=> !seq_err);

endmodule

// File: tb/hc_cmdsts_regs_test.sv
`timescale 1ns/1ps
module hc_cmdsts_regs_test;
    localparam logic [7:0] A_CMD = 8'h20;
    localparam logic [7:0] A_STS = 8'h24;
    localparam logic [7:0] A_OTH = 8'h28;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [5:0]  evt_in;
    logic        eng_idle, rst_done;
    logic [31:0] rdata, rdata_f;
    logic        run_req, hc_reset_req, per_en, async_en, seq_err;
    logic        run_req_f, hc_reset_req_f, per_en_f, async_en_f, seq_err_f;
    logic [9:0]  fidx_mask, fidx_mask_f;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hc_cmdsts_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata), .evt_in(evt_in),
        .eng_idle(eng_idle), .rst_done(rst_done), .run_req(run_req),
        .hc_reset_req(hc_reset_req), .per_en(per_en), .async_en(async_en),
        .fidx_mask(fidx_mask), .seq_err(seq_err)
    );

    hc_cmdsts_regs #(.PROG_FLS(1'b0)) uut_fixed (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_f), .evt_in(evt_in),
        .eng_idle(eng_idle), .rst_done(rst_done), .run_req(run_req_f),
        .hc_reset_req(hc_reset_req_f), .per_en(per_en_f), .async_en(async_en_f),
        .fidx_mask(fidx_mask_f), .seq_err(seq_err_f)
    );

    // {write data, expected command word, expected mask}
    localparam logic [73:0] VEC [6] = '{
        {32'hFFFF_FFC4, 32'h0000_0004, 10'h1FF},
        {32'h0000_0038, 32'h0000_0038, 10'h0FF},
        {32'h0000_000C, 32'h0000_0008, 10'h0FF},
        {32'h0000_0010, 32'h0000_0010, 10'h3FF},
        {32'h0000_0020, 32'h0000_0020, 10'h3FF},
        {32'h0000_0000, 32'h0000_0000, 10'h3FF}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        bus_addr = a;
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        evt_in = '0; eng_idle = 1'b1; rst_done = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_CMD); chk("R1 cmd", rdata, 32'h0);
        rd(A_STS); chk("R1 sts", rdata, 32'h0000_1000);
        chk("R1 mask", 32'(fidx_mask), 32'h3FF);

        // R6 R7 R8 R9 vector walk
        for (int i = 0; i < 6; i++) begin
            wr(A_CMD, VEC[i][73:42]);
            rd(A_CMD);
            chk("R6/R8/R9 cmd", rdata, VEC[i][41:10]);
            chk("R6 mask", 32'(fidx_mask), 32'(VEC[i][9:0]));
            chk("R8 enables", {30'b0, async_en, per_en}, {30'b0, VEC[i][15], VEC[i][14]});
            chk("R7 fixed cmd", rdata_f, VEC[i][41:10] & ~32'hC);
            chk("R7 fixed mask", 32'(fidx_mask_f), 32'h3FF);
        end

        // R12 other offset
        wr(A_OTH, 32'h0000_003F);
        rd(A_OTH); chk("R12 read other", rdata, 32'h0);
        rd(A_CMD); chk("R12 cmd untouched", rdata, 32'h0);

        // R2 run handshake
        wr(A_CMD, 32'h1);
        chk("R2 run_req", 32'(run_req), 32'h1);
        rd(A_STS); chk("R2 halted still 1", rdata, 32'h0000_1000);
        @(negedge clk);
        rd(A_STS); chk("R2 halted 0", rdata, 32'h0);

        // R3 drain-then-halt
        eng_idle = 1'b0;
        wr(A_CMD, 32'h0);
        repeat (3) @(negedge clk);
        rd(A_STS); chk("R3 busy keeps running", rdata, 32'h0);
        eng_idle = 1'b1;
        @(negedge clk);
        rd(A_STS); chk("R3 halted after idle", rdata, 32'h0000_1000);

        // R10 events
        @(negedge clk); evt_in = 6'b001001;
        @(negedge clk); evt_in = '0;
        rd(A_STS); chk("R10 set", rdata, 32'h0000_1009);
        wr(A_STS, 32'h0000_1001);
        rd(A_STS); chk("R10 w1c", rdata, 32'h0000_1008);
        wr(A_STS, 32'h0);
        rd(A_STS); chk("R10 write 0", rdata, 32'h0000_1008);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = A_STS; bus_wdata = 32'h8; evt_in = 6'b001000;
        @(negedge clk);
        bus_wr = 1'b0; evt_in = '0;
        rd(A_STS); chk("R10 set beats clear", rdata, 32'h0000_1008);

        // R11 legal reset while halted
        wr(A_CMD, 32'h2);
        chk("R11 legal no flag", 32'(seq_err), 32'h0);
        chk("R4 reset_req", 32'(hc_reset_req), 32'h1);
        @(negedge clk); rst_done = 1'b1;
        @(negedge clk); rst_done = 1'b0;
        chk("R4 self clear", 32'(hc_reset_req), 32'h0);
        rd(A_STS); chk("R5 sts cleared", rdata, 32'h0000_1000);

        // R11 illegal reset while running, R4 no abort, R5 defaults
        wr(A_CMD, 32'h1);
        @(negedge clk);
        @(negedge clk); evt_in = 6'b100000;
        @(negedge clk); evt_in = '0;
        wr(A_CMD, 32'h0000_0037);
        chk("R11 flag", 32'(seq_err), 32'h1);
        @(negedge clk);
        chk("R11 one cycle", 32'(seq_err), 32'h0);
        wr(A_CMD, 32'h0000_0035);
        rd(A_CMD); chk("R4 write 0 no abort", rdata, 32'h0000_0037);
        @(negedge clk); rst_done = 1'b1;
        @(negedge clk); rst_done = 1'b0;
        rd(A_CMD); chk("R5 cmd cleared", rdata, 32'h0);
        rd(A_STS); chk("R5 sts cleared", rdata, 32'h0000_1000);
        chk("R5 mask", 32'(fidx_mask), 32'h3FF);

        finish_run();
    end
endmodule